// File: doc/BRIEF.md
# Threshold-Select Correlation Peak Detector

This block sits after a bank of binary correlators and picks the strongest target match in one image region. Every input beat stands for one template at one relative offset. It carries eight bright/surround correlation pairs, one for each of eight fixed threshold levels, and a shapesum value for that offset. The shapesum is compared against seven ascending boundaries to choose one threshold level. The pair at that level becomes a signed score equal to bright minus surround.

A running maximum keeps the best score seen since the last start-of-chip strobe, along with the template index, raster offset and threshold level that produced it. When the end-of-chip strobe is accepted, the block holds off new input for two cycles while the pipeline drains. It then pulses a one-cycle result carrying the winner. Equal scores go to the lower template index, then to the lower offset, whatever the arrival order.

Top module: `tsel_peak_detect`

## Requirements
- R1: The selected level is the count of boundaries that are less than or equal to the shapesum. Boundary j sits at `level_bounds[12*j +: 12]`, for j from 0 to 6. Level k takes its bright and surround values from bits `[6*k +: 6]` of `in_bright` and `in_surround`, and the winner's level appears on `res_level`.
- R2: The score is bright minus surround at the selected level, as a 7-bit two's complement value from -63 to +63, reported on `res_score`.
- R3: The reported winner is the accepted beat with the highest score since the last start-of-chip strobe, with its template index and offset.
- R4: On equal scores the beat with the lower template index wins, and on equal index the lower offset wins, regardless of arrival order.
- R5: A `chip_start` pulse while `in_ready` is high clears the running maximum, so earlier beats do not affect the next report.
- R6: A `chip_end` accepted in cycle e gives `res_valid` high for exactly one cycle, three cycles later. A beat accepted in cycle e itself is included.
- R7: A beat counts only when `in_valid` and `in_ready` are both high. `in_ready` is low for the two cycles after an accepted `chip_end`, and beats offered then are dropped.
- R8: A report with no accepted beats since the clear has `res_found` at 0 and score, template, offset and level at 0.
- R9: After reset, `in_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_start | input | 1 | Clears the running maximum |
| chip_end | input | 1 | Requests the report for the current chip |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_tpl | input | 8 | Template index of the beat |
| in_ofs | input | 14 | Raster offset of the beat |
| in_shapesum | input | 12 | Shapesum used for level choice |
| in_bright | input | 48 | Eight 6-bit bright correlations |
| in_surround | input | 48 | Eight 6-bit surround correlations |
| level_bounds | input | 84 | Seven 12-bit ascending boundaries |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | At least one beat was scored |
| res_tpl | output | 8 | Winning template index |
| res_ofs | output | 14 | Winning offset |
| res_score | output | 7 | Winning signed score |
| res_level | output | 3 | Threshold level of the winner |

## Verification
Single-beat chips sweep the shapesum below, at and above several boundaries and at both extremes. Every unselected level is filled with a distinct decoy score, so a wrong level pick shows up as a wrong score or level. Multi-beat chips with positive and negative scores check the running maximum. Equal-score beats sent out of index order separate a "first seen" policy from the required lowest-index/lowest-offset policy. Further chips cover a clear after a strong beat, an empty chip, a beat sent together with the end strobe, high-scoring beats offered while the input is held off, and a high score shown with valid low.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int NUM_LEVELS = 8;
    localparam int CORR_W     = 6;
    localparam int SHAPE_W    = 12;
    localparam int TPL_W      = 8;
    localparam int OFS_W      = 14;

    localparam int NUM_BOUNDS = NUM_LEVELS - 1;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam int SCORE_W    = CORR_W + 1;
    localparam int KEY_W      = TPL_W + OFS_W;

    typedef logic signed [SCORE_W-1:0] score_t;

    typedef struct packed {
        score_t             score;
        logic [TPL_W-1:0]   tpl;
        logic [OFS_W-1:0]   ofs;
        logic [LVL_W-1:0]   level;
    } cand_t;

    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_DRAIN  = 2'd1,
        PH_REPORT = 2'd2
    } phase_t;

    // Signed difference of two unsigned correlation counts.
    function automatic score_t pair_score(input logic [CORR_W-1:0] bright,
                                          input logic [CORR_W-1:0] surround);
        return $signed({1'b0, bright}) - $signed({1'b0, surround});
    endfunction

    // True when the incoming candidate should replace the held one.
    function automatic logic replaces(input cand_t held, input cand_t inc);
        logic [KEY_W-1:0] k_held;
        logic [KEY_W-1:0] k_inc;
        k_held = {held.tpl, held.ofs};
        k_inc  = {inc.tpl, inc.ofs};
        if ($signed(inc.score) > $signed(held.score))
            return 1'b1;
        if (($signed(inc.score) == $signed(held.score)) && (k_inc < k_held))
            return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/tsel_level_pick.sv
module tsel_level_pick
    import tsel_pkg::*;
(
    input  logic [SHAPE_W-1:0]            shapesum,
    input  logic [NUM_BOUNDS*SHAPE_W-1:0] bounds,
    output logic [LVL_W-1:0]              level
);

    logic [NUM_BOUNDS-1:0] at_or_above;

    generate
        for (genvar j = 0; j < NUM_BOUNDS; j++) begin : g_cmp
            assign at_or_above[j] = (shapesum >= bounds[j*SHAPE_W +: SHAPE_W]);
        end
    endgenerate

    always_comb begin
        level = '0;
        for (int j = 0; j < NUM_BOUNDS; j++) begin
            level = level + LVL_W'(at_or_above[j]);
        end
    end

endmodule

// File: rtl/tsel_score_stage.sv
module tsel_score_stage
    import tsel_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          take,
    input  logic [TPL_W-1:0]              tpl,
    input  logic [OFS_W-1:0]              ofs,
    input  logic [SHAPE_W-1:0]            shapesum,
    input  logic [NUM_LEVELS*CORR_W-1:0]  bright,
    input  logic [NUM_LEVELS*CORR_W-1:0]  surround,
    input  logic [NUM_BOUNDS*SHAPE_W-1:0] bounds,
    output logic                          out_valid,
    output cand_t                         out_cand
);

    logic [LVL_W-1:0]  lvl;
    logic [CORR_W-1:0] b_sel;
    logic [CORR_W-1:0] s_sel;
    cand_t             nxt;

    tsel_level_pick u_pick (
        .shapesum (shapesum),
        .bounds   (bounds),
        .level    (lvl)
    );

    always_comb begin
        b_sel     = bright[lvl*CORR_W +: CORR_W];
        s_sel     = surround[lvl*CORR_W +: CORR_W];
        nxt.score = pair_score(b_sel, s_sel);
        nxt.tpl   = tpl;
        nxt.ofs   = ofs;
        nxt.level = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_cand  <= '0;
        end else begin
            out_valid <= take;
            if (take) begin
                out_cand <= nxt;
            end
        end
    end

endmodule

// File: rtl/tsel_peak_track.sv
module tsel_peak_track
    import tsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  upd_valid,
    input  cand_t upd_cand,
    output logic  have,
    output cand_t best
);

    logic take_new;

    assign take_new = upd_valid && (!have || replaces(best, upd_cand));

    // A clear wins over an update that arrives at the same edge.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have <= 1'b0;
            best <= '0;
        end else if (take_new) begin
            have <= 1'b1;
            best <= upd_cand;
        end
    end

endmodule

// File: rtl/tsel_peak_detect.sv
module tsel_peak_detect
    import tsel_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          chip_start,
    input  logic                          chip_end,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [TPL_W-1:0]              in_tpl,
    input  logic [OFS_W-1:0]              in_ofs,
    input  logic [SHAPE_W-1:0]            in_shapesum,
    input  logic [NUM_LEVELS*CORR_W-1:0]  in_bright,
    input  logic [NUM_LEVELS*CORR_W-1:0]  in_surround,
    input  logic [NUM_BOUNDS*SHAPE_W-1:0] level_bounds,
    output logic                          res_valid,
    output logic                          res_found,
    output logic [TPL_W-1:0]              res_tpl,
    output logic [OFS_W-1:0]              res_ofs,
    output logic [SCORE_W-1:0]            res_score,
    output logic [LVL_W-1:0]              res_level
);

    phase_t phase;
    logic   take;
    logic   st_valid;
    cand_t  st_cand;
    logic   trk_have;
    cand_t  trk_best;
    logic   trk_clear;

    assign in_ready  = (phase == PH_RUN);
    assign take      = in_valid && in_ready;
    assign trk_clear = chip_start && in_ready;

    tsel_score_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .tpl       (in_tpl),
        .ofs       (in_ofs),
        .shapesum  (in_shapesum),
        .bright    (in_bright),
        .surround  (in_surround),
        .bounds    (level_bounds),
        .out_valid (st_valid),
        .out_cand  (st_cand)
    );

    tsel_peak_track u_track (
        .clk       (clk),
        .rst       (rst),
        .clear     (trk_clear),
        .upd_valid (st_valid),
        .upd_cand  (st_cand),
        .have      (trk_have),
        .best      (trk_best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RUN;
        end else begin
            unique case (phase)
                PH_RUN:    if (chip_end) phase <= PH_DRAIN;
                PH_DRAIN:  phase <= PH_REPORT;
                PH_REPORT: phase <= PH_RUN;
                default:   phase <= PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_found <= 1'b0;
            res_tpl   <= '0;
            res_ofs   <= '0;
            res_score <= '0;
            res_level <= '0;
        end else begin
            res_valid <= (phase == PH_REPORT);
            if (phase == PH_REPORT) begin
                res_found <= trk_have;
                res_tpl   <= trk_best.tpl;
                res_ofs   <= trk_best.ofs;
                res_score <= trk_best.score;
                res_level <= trk_best.level;
            end
        end
    end

endmodule

// File: rtl/tsel_peak_detect_chk.sv
module tsel_peak_detect_chk
    import tsel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               chip_end,
    input logic               in_ready,
    input logic               res_valid,
    input logic               res_found,
    input logic [SCORE_W-1:0] res_score
);

    AST_END_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        chip_end && in_ready |=> !in_ready);                              // R7

    AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> ##2 in_ready);                                // R7

    AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> in_ready);                                          // R7

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        chip_end && in_ready |-> ##3 res_valid);                          // R6

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);                                        // R6

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_found |-> res_score == '0);                     // R8

endmodule

bind tsel_peak_detect tsel_peak_detect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chip_end  (chip_end),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .res_found (res_found),
    .res_score (res_score)
);

// File: tb/test_tsel_peak_detect.sv
module test_tsel_peak_detect;
    import tsel_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          chip_start;
    logic                          chip_end;
    logic                          in_valid;
    logic                          in_ready;
    logic [TPL_W-1:0]              in_tpl;
    logic [OFS_W-1:0]              in_ofs;
    logic [SHAPE_W-1:0]            in_shapesum;
    logic [NUM_LEVELS*CORR_W-1:0]  in_bright;
    logic [NUM_LEVELS*CORR_W-1:0]  in_surround;
    logic [NUM_BOUNDS*SHAPE_W-1:0] level_bounds;
    logic                          res_valid;
    logic                          res_found;
    logic [TPL_W-1:0]              res_tpl;
    logic [OFS_W-1:0]              res_ofs;
    logic [SCORE_W-1:0]            res_score;
    logic [LVL_W-1:0]              res_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference state, built from the requirements
    bit m_have;
    int m_score, m_tpl, m_ofs, m_lvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsel_peak_detect i_tsel_peak_detect (
        .clk          (clk),
        .rst          (rst),
        .chip_start   (chip_start),
        .chip_end     (chip_end),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_tpl       (in_tpl),
        .in_ofs       (in_ofs),
        .in_shapesum  (in_shapesum),
        .in_bright    (in_bright),
        .in_surround  (in_surround),
        .level_bounds (level_bounds),
        .res_valid    (res_valid),
        .res_found    (res_found),
        .res_tpl      (res_tpl),
        .res_ofs      (res_ofs),
        .res_score    (res_score),
        .res_level    (res_level)
    );

    function automatic int bound_of(input int j);
        return 100 * (j + 1);
    endfunction

    function automatic int ref_level(input int ss);
        int n = 0;
        for (int j = 0; j < NUM_BOUNDS; j++) if (bound_of(j) <= ss) n++;
        return n;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_have = 0; m_score = 0; m_tpl = 0; m_ofs = 0; m_lvl = 0;
    endtask

    // Drive one cycle of input; decoys at unselected levels score k-10.
    task automatic put(input bit v, input int tpl, input int ofs, input int ss,
                       input int b, input int s);
        int lv;
        int sc;
        lv = ref_level(ss);
        in_valid    = v;
        in_tpl      = TPL_W'(tpl);
        in_ofs      = OFS_W'(ofs);
        in_shapesum = SHAPE_W'(ss);
        for (int k = 0; k < NUM_LEVELS; k++) begin
            in_bright[k*CORR_W +: CORR_W]   = CORR_W'((k == lv) ? b : 10 + k);
            in_surround[k*CORR_W +: CORR_W] = CORR_W'((k == lv) ? s : 20);
        end
        if (v && in_ready) begin
            sc = b - s;
            if (!m_have || sc > m_score ||
                (sc == m_score && (tpl < m_tpl || (tpl == m_tpl && ofs < m_ofs)))) begin
                m_have = 1; m_score = sc; m_tpl = tpl; m_ofs = ofs; m_lvl = lv;
            end
        end
        @(negedge clk);
    endtask

    task automatic start_chip();
        chip_start = 1'b1;
        put(0, 0, 0, 0, 0, 0);
        chip_start = 1'b0;
        model_clear();
    endtask

    // End the chip, optionally with a beat in the same cycle and with
    // strong beats offered while input is held off.
    task automatic finish_chip(input string req, input bit with_beat,
                               input int tpl, input int ofs, input int ss,
                               input int b, input int s, input bit offer_late);
        chip_end = 1'b1;
        put(with_beat, tpl, ofs, ss, b, s);
        chip_end = 1'b0;
        chk("R7", "ready low 1st cycle after end", int'(in_ready), 0);
        put(offer_late, 0, 0, 4095, 63, 0);
        chk("R7", "ready low 2nd cycle after end", int'(in_ready), 0);
        chk("R6", "no early result", int'(res_valid), 0);
        put(offer_late, 0, 0, 4095, 63, 0);
        chk("R6", "result strobe", int'(res_valid), 1);
        chk("R7", "ready back", int'(in_ready), 1);
        chk(req, "found", int'(res_found), int'(m_have));
        chk(req, "score", int'($signed(res_score)), m_score);
        chk(req, "template", int'(res_tpl), m_tpl);
        chk(req, "offset", int'(res_ofs), m_ofs);
        chk(req, "level", int'(res_level), m_lvl);
        put(0, 0, 0, 0, 0, 0);
        chk("R6", "strobe one cycle", int'(res_valid), 0);
    endtask

    task automatic t_reset();
        chk("R9", "ready after reset", int'(in_ready), 1);
        chk("R9", "no result after reset", int'(res_valid), 0);
    endtask

    // R1 and R2: one beat per chip across boundary cases
    task automatic t_level_sweep();
        int ss_list[9] = '{0, 99, 100, 150, 399, 400, 699, 700, 4095};
        int b_list[9]  = '{63, 5, 0, 33, 17, 40, 1, 63, 30};
        int s_list[9]  = '{0, 40, 63, 33, 2, 41, 9, 62, 12};
        for (int i = 0; i < 9; i++) begin
            start_chip();
            put(1, i, 100 + i, ss_list[i], b_list[i], s_list[i]);
            chk("R1", "model level", m_lvl, ref_level(ss_list[i]));
            finish_chip("R1", 0, 0, 0, 0, 0, 0, 0);
            chk("R2", "score of sweep beat", m_score, b_list[i] - s_list[i]);
        end
    endtask

    // R3: maximum over many beats with mixed signs
    task automatic t_max_search();
        start_chip();
        for (int t = 0; t < 6; t++) begin
            for (int o = 0; o < 20; o++) begin
                put(1, t, o, (t * 137 + o * 53) % 900,
                    (t * 11 + o * 7) % 64, (t * 5 + o * 13) % 64);
            end
        end
        finish_chip("R3", 0, 0, 0, 0, 0, 0, 0);
    endtask

    // R4: equal scores arriving out of order
    task automatic t_ties();
        start_chip();
        put(1, 5, 10, 250, 40, 10);
        put(1, 3, 20, 550, 35, 5);
        put(1, 3, 15, 50, 31, 1);
        put(1, 4, 1, 750, 30, 0);
        put(1, 3, 16, 350, 45, 15);
        finish_chip("R4", 0, 0, 0, 0, 0, 0, 0);
        chk("R4", "tie winner offset", m_ofs, 15);
    endtask

    // R5: clear discards an earlier strong beat
    task automatic t_restart();
        start_chip();
        put(1, 1, 1, 500, 63, 0);
        put(0, 0, 0, 0, 0, 0);
        put(0, 0, 0, 0, 0, 0);
        start_chip();
        put(1, 9, 77, 120, 10, 15);
        finish_chip("R5", 0, 0, 0, 0, 0, 0, 0);
        chk("R5", "score after clear", m_score, -5);
    endtask

    // R8: nothing accepted
    task automatic t_empty();
        start_chip();
        put(0, 0, 0, 4095, 63, 0);
        finish_chip("R8", 0, 0, 0, 0, 0, 0, 0);
    endtask

    // R6, R7: beat with the end strobe counts; beats while held off and
    // beats without valid do not.
    task automatic t_handshake();
        start_chip();
        put(1, 2, 30, 300, 20, 10);
        put(0, 0, 0, 4095, 63, 0);
        finish_chip("R6", 1, 2, 31, 300, 30, 10, 1);
        chk("R7", "late beats ignored", m_score, 20);
    endtask

    initial begin
        rst          = 1'b1;
        chip_start   = 1'b0;
        chip_end     = 1'b0;
        in_valid     = 1'b0;
        in_tpl       = '0;
        in_ofs       = '0;
        in_shapesum  = '0;
        in_bright    = '0;
        in_surround  = '0;
        for (int j = 0; j < NUM_BOUNDS; j++)
            level_bounds[j*SHAPE_W +: SHAPE_W] = SHAPE_W'(bound_of(j));
        model_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_level_sweep();
        t_max_search();
        t_ties();
        t_restart();
        t_empty();
        t_handshake();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule